// File: doc/BRIEF.md
# GPIO Port Interrupt Controller

This block watches the input pins of one GPIO port, up to 32 of them, and turns selected pin activity into a single interrupt request for a parent interrupt controller. Each pin has a two-bit trigger code that picks one of four conditions: high level, low level, rising edge or falling edge. A detected condition sets that pin's bit in a pending word. The pending bit and a per-pin enable bit in a mask word are combined with a port-wide enable to drive the interrupt line.

Software reaches the block through a simple synchronous bus with separate write and read strobes, a byte address and 32-bit data. Pending bits and the port flag are cleared by writing 1. A control word holds the port enable, a choice of a slower sampling rate for the pins, and a port flag that summarises whether the port is requesting service. The hardware detects only one edge per pin at a time. When both edges are needed, software flips the trigger code after each event.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset every register reads zero, `irq_out` is low and `bus_rdata` is zero.
- R2: Trigger codes are 0 high level, 1 low level, 2 rising edge, 3 falling edge. The code for pin p sits at bits (p mod 16)*2+1:(p mod 16)*2. Pins 0–15 use the word at address 0x10 and pins 16–31 use the word at address 0x0C. Both words read back what was written.
- R3: A rising or falling edge on a pin whose code selects that edge sets the pin's pending bit. An edge of the other direction does not. If the change is applied between clock edges, `irq_out` (mask and enable set) stays low at the third clock edge and goes high at the fourth.
- R4: A level-type pin has its pending bit set again on every sample while the level is present. A write-1 clear therefore only holds once the pin has left the level.
- R5: Writing 1 to a bit of the pending word (address 0x04) clears it. Writing 0 leaves it unchanged. Pending bits never fall without such a write.
- R6: When a detected event and a write-1 clear reach the same pending bit on the same clock edge, the bit ends up set.
- R7: The mask word (address 0x08) bit 1 enables a pin. Control bit 1 enables the port. `irq_out` is high exactly when, one edge earlier, the port was enabled and some pin had both pending and mask set. Pending bits latch even while masked.
- R8: Control word (address 0x00): bit 1 enable and bit 2 slow sampling are read/write. Bit 0 is the port flag. It is set whenever the interrupt condition of R7 holds, cleared by writing 1 to bit 0, and stays set if the condition still holds.
- R9: On a port with fewer than 32 pins, pending, mask and trigger bits above the pin count read as zero and writes to them are ignored.
- R10: With control bit 2 set, pins are compared only once every SLOW_DIV clock cycles. An edge held steady is still latched within SLOW_DIV+3 cycles.
- R11: `bus_rdata` is registered. It shows the addressed register one edge after `bus_re` and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | NPINS | Asynchronous GPIO pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
Two functions can land on the same pending bit in one cycle: an edge event set by the detector and a software write-1 clear. The bench places a rising pin change two cycles before a clear write, so that both reach the pending register on the same clock edge. Reading back a 1 is judged correct. A plain clear with no event, which must read 0, serves as the control case. The same kind of collision on the port flag is covered by clearing the flag while a masked-in pending bit still holds it set.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int BUS_AW = 5;
  localparam int BUS_DW = 32;

  localparam logic [BUS_AW-1:0] OFS_CTRL    = 5'h00;
  localparam logic [BUS_AW-1:0] OFS_PEND    = 5'h04;
  localparam logic [BUS_AW-1:0] OFS_MASK    = 5'h08;
  localparam logic [BUS_AW-1:0] OFS_TYPE_HI = 5'h0C;
  localparam logic [BUS_AW-1:0] OFS_TYPE_LO = 5'h10;

  localparam int CTL_FLAG = 0;
  localparam int CTL_EN   = 1;
  localparam int CTL_SLOW = 2;

  localparam int PINS_PER_TYPE_WORD = 16;

  typedef enum logic [1:0] {
    TRIG_LVL_HI = 2'd0,
    TRIG_LVL_LO = 2'd1,
    TRIG_RISE   = 2'd2,
    TRIG_FALL   = 2'd3
  } trig_e;
endpackage

// File: rtl/gpio_irq_tick.sv
`timescale 1ns/1ps
module gpio_irq_tick #(
  parameter int SLOW_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic slow,
  output logic tick
);
  localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(SLOW_DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = slow ? (cnt_q == '0) : 1'b1;
endmodule

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [NPINS-1:0] din,
  output logic [NPINS-1:0] cur,
  output logic [NPINS-1:0] prv
);
  logic [NPINS-1:0] meta_q, stab_q, prv_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
      prv_q  <= '0;
    end else begin
      meta_q <= din;
      stab_q <= meta_q;
      if (tick) prv_q <= stab_q;
    end
  end

  assign cur = stab_q;
  assign prv = prv_q;
endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               tick,
  input  logic [NPINS-1:0]   cur,
  input  logic [NPINS-1:0]   prv,
  input  logic [2*NPINS-1:0] trig,
  output logic [NPINS-1:0]   evt
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    trig_e code;
    assign code = trig_e'(trig[2*g +: 2]);
    always_comb begin
      unique case (code)
        TRIG_LVL_HI: evt[g] = tick &  cur[g];
        TRIG_LVL_LO: evt[g] = tick & ~cur[g];
        TRIG_RISE:   evt[g] = tick &  cur[g] & ~prv[g];
        TRIG_FALL:   evt[g] = tick & ~cur[g] &  prv[g];
        default:     evt[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [BUS_DW-1:0]  bus_wdata,
  input  logic [NPINS-1:0]   evt,
  output logic [NPINS-1:0]   pend,
  output logic [NPINS-1:0]   mask,
  output logic               en,
  output logic               slow,
  output logic               flag,
  output logic [2*NPINS-1:0] trig,
  output logic [BUS_DW-1:0]  rdata,
  output logic               irq
);
  localparam int HALF = PINS_PER_TYPE_WORD;

  logic [NPINS-1:0]      pend_q, mask_q;
  logic [NPINS-1:0][1:0] trig_q;
  logic                  en_q, slow_q, flag_q, irq_q;
  logic [BUS_DW-1:0]     rdata_q, rd_mux, type_lo_rd, type_hi_rd;
  logic                  wr_ctrl, wr_pend, wr_mask, wr_tlo, wr_thi, cond;
  logic [NPINS-1:0]      clr_bits;

  assign wr_ctrl  = bus_we && (bus_addr == OFS_CTRL);
  assign wr_pend  = bus_we && (bus_addr == OFS_PEND);
  assign wr_mask  = bus_we && (bus_addr == OFS_MASK);
  assign wr_tlo   = bus_we && (bus_addr == OFS_TYPE_LO);
  assign wr_thi   = bus_we && (bus_addr == OFS_TYPE_HI);
  assign clr_bits = wr_pend ? bus_wdata[NPINS-1:0] : '0;
  assign cond     = en_q && |(pend_q & mask_q);

  always_comb begin
    type_lo_rd = '0;
    type_hi_rd = '0;
    for (int i = 0; i < NPINS; i++) begin
      if (i < HALF) type_lo_rd[2*(i%HALF) +: 2] = trig_q[i];
      else          type_hi_rd[2*(i%HALF) +: 2] = trig_q[i];
    end
  end

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL:    rd_mux = {29'd0, slow_q, en_q, flag_q};
      OFS_PEND:    rd_mux = BUS_DW'(pend_q);
      OFS_MASK:    rd_mux = BUS_DW'(mask_q);
      OFS_TYPE_HI: rd_mux = type_hi_rd;
      OFS_TYPE_LO: rd_mux = type_lo_rd;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      mask_q  <= '0;
      trig_q  <= '0;
      en_q    <= 1'b0;
      slow_q  <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_bits) | evt;
      if (wr_mask) mask_q <= bus_wdata[NPINS-1:0];
      if (wr_ctrl) begin
        en_q   <= bus_wdata[CTL_EN];
        slow_q <= bus_wdata[CTL_SLOW];
      end
      flag_q <= cond | (flag_q & ~(wr_ctrl & bus_wdata[CTL_FLAG]));
      irq_q  <= cond;
      for (int i = 0; i < NPINS; i++) begin
        if (i < HALF) begin
          if (wr_tlo) trig_q[i] <= bus_wdata[2*(i%HALF) +: 2];
        end else begin
          if (wr_thi) trig_q[i] <= bus_wdata[2*(i%HALF) +: 2];
        end
      end
      if (bus_re) rdata_q <= rd_mux;
    end
  end

  assign pend  = pend_q;
  assign mask  = mask_q;
  assign en    = en_q;
  assign slow  = slow_q;
  assign flag  = flag_q;
  assign trig  = trig_q;
  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int NPINS    = 32,
  parameter int SLOW_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output logic              irq_out
);
  logic               tick, slow, en, flag;
  logic [NPINS-1:0]   cur, prv, evt, pend, mask;
  logic [2*NPINS-1:0] trig;

  gpio_irq_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
    .clk(clk), .rst(rst), .slow(slow), .tick(tick)
  );

  gpio_irq_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst(rst), .tick(tick), .din(pin_in), .cur(cur), .prv(prv)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .tick(tick), .cur(cur), .prv(prv), .trig(trig), .evt(evt)
  );

  gpio_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .evt(evt),
    .pend(pend), .mask(mask), .en(en), .slow(slow), .flag(flag),
    .trig(trig), .rdata(bus_rdata), .irq(irq_out)
  );
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [NPINS-1:0]  evt,
  input logic [NPINS-1:0]  pend,
  input logic              en,
  input logic              flag,
  input logic              irq_out,
  input logic              bus_we,
  input logic [BUS_AW-1:0] bus_addr,
  input logic [BUS_DW-1:0] bus_wdata
);
  // R6
  evt_sets_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> (|pend));

  // R5
  pend_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_we && bus_addr == OFS_PEND) |=> ((pend & $past(pend)) == $past(pend)));

  // R7
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq_out);

  // R8
  irq_implies_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> flag);

  // R8
  flag_clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> $past(bus_we && bus_addr == OFS_CTRL && bus_wdata[CTL_FLAG]));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .evt(evt), .pend(pend), .en(en), .flag(flag),
  .irq_out(irq_out), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;
  localparam int NP   = 32;
  localparam int NN   = 12;
  localparam int SDIV = 4;

  localparam logic [4:0] A_CTRL = 5'h00;
  localparam logic [4:0] A_PEND = 5'h04;
  localparam logic [4:0] A_MASK = 5'h08;
  localparam logic [4:0] A_THI  = 5'h0C;
  localparam logic [4:0] A_TLO  = 5'h10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pins = '0;
  logic          we = 1'b0, re = 1'b0;
  logic [4:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rd_main, rd_nar;
  logic          irq_main, irq_nar;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  gpio_irq_port #(.NPINS(NP), .SLOW_DIV(SDIV)) u_gpio_irq_port (
    .clk(clk), .rst(rst), .pin_in(pins), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_main), .irq_out(irq_main)
  );

  gpio_irq_port #(.NPINS(NN), .SLOW_DIV(SDIV)) u_narrow (
    .clk(clk), .rst(rst), .pin_in(pins[NN-1:0]), .bus_we(we), .bus_re(re),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd_nar), .irq_out(irq_nar)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pins = '0; we = 1'b0; re = 1'b0;
    cyc(2);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] dm, output logic [31:0] dn);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    dm = rd_main; dn = rd_nar;
  endtask

  task automatic t_reset();
    logic [31:0] m, n;
    do_reset();
    check("R1 irq after reset", 32'(irq_main), 32'd0);
    check("R1 rdata after reset", rd_main, 32'd0);
    rd(A_CTRL, m, n); check("R1 ctrl", m, 32'd0);
    rd(A_PEND, m, n); check("R1 pend", m, 32'd0);
    rd(A_MASK, m, n); check("R1 mask", m, 32'd0);
    rd(A_TLO,  m, n); check("R1 type lo", m, 32'd0);
  endtask

  task automatic t_type_pack();
    logic [31:0] m, n;
    do_reset();
    wr(A_TLO, 32'h0000_00E4);
    wr(A_THI, 32'h0000_0002);
    rd(A_TLO, m, n); check("R2 type lo readback", m, 32'h0000_00E4);
    rd(A_THI, m, n); check("R2 type hi readback", m, 32'h0000_0002);
    wr(A_PEND, 32'hFFFF_FFFF);
    cyc(4);
    rd(A_PEND, m, n); check("R2 only low-level pin1 pending", m, 32'h0000_0002);
    pins[16] = 1'b1;
    cyc(4);
    rd(A_PEND, m, n); check("R2 pin16 rise via hi word", m & 32'h0001_0000, 32'h0001_0000);
  endtask

  task automatic t_edges();
    logic [31:0] m, n;
    do_reset();
    wr(A_TLO, (32'd2 << 6) | (32'd3 << 10));
    wr(A_MASK, 32'h0000_0008);
    wr(A_CTRL, 32'h0000_0002);
    pins[3] = 1'b1;
    cyc(3); check("R3 irq low at 3rd edge", 32'(irq_main), 32'd0);
    cyc(1); check("R3 irq high at 4th edge", 32'(irq_main), 32'd1);
    rd(A_PEND, m, n); check("R3 rise pin3 pending", m, 32'h0000_0008);
    wr(A_PEND, 32'h0000_0008);
    pins[5] = 1'b1;
    cyc(4);
    rd(A_PEND, m, n); check("R3 rise ignored by fall pin5", m, 32'd0);
    pins[5] = 1'b0; pins[3] = 1'b0;
    cyc(4);
    rd(A_PEND, m, n); check("R3 fall pin5 pending, pin3 fall ignored", m, 32'h0000_0020);
  endtask

  task automatic t_level();
    logic [31:0] m, n;
    do_reset();
    wr(A_TLO, 32'd1 << 18);
    cyc(2);
    rd(A_PEND, m, n); check("R4 low-level pin9 pending", m, 32'h0000_0200);
    pins[7] = 1'b1;
    cyc(4);
    wr(A_PEND, 32'h0000_0080);
    rd(A_PEND, m, n); check("R4 high level re-sets after clear", m & 32'h80, 32'h80);
    pins[7] = 1'b0;
    cyc(3);
    wr(A_PEND, 32'h0000_0080);
    rd(A_PEND, m, n); check("R4 clear holds after level gone", m & 32'h80, 32'h0);
  endtask

  task automatic t_clear_collide();
    logic [31:0] m, n;
    do_reset();
    wr(A_TLO, 32'd2 << 4);
    pins[2] = 1'b1; cyc(4);
    pins[2] = 1'b0; cyc(4);
    wr(A_PEND, 32'h0000_0000);
    rd(A_PEND, m, n); check("R5 write 0 keeps pending", m, 32'h0000_0004);
    pins[2] = 1'b1;
    cyc(2);
    wr(A_PEND, 32'h0000_0004);
    rd(A_PEND, m, n); check("R6 set wins over same-edge clear", m, 32'h0000_0004);
    wr(A_PEND, 32'h0000_0004);
    rd(A_PEND, m, n); check("R5 write 1 clears", m, 32'h0000_0000);
  endtask

  task automatic t_mask_ctrl();
    logic [31:0] m, n;
    do_reset();
    wr(A_TLO, 32'd2 << 6);
    wr(A_CTRL, 32'h0000_0002);
    pins[3] = 1'b1; cyc(4);
    check("R7 masked pin gives no irq", 32'(irq_main), 32'd0);
    rd(A_PEND, m, n); check("R7 pending latched while masked", m, 32'h0000_0008);
    wr(A_MASK, 32'h0000_0008);
    cyc(1);
    check("R7 irq after unmask", 32'(irq_main), 32'd1);
    rd(A_CTRL, m, n); check("R8 port flag set", m, 32'h0000_0003);
    wr(A_CTRL, 32'h0000_0003);
    rd(A_CTRL, m, n); check("R8 flag stays while condition holds", m, 32'h0000_0003);
    wr(A_PEND, 32'h0000_0008);
    wr(A_CTRL, 32'h0000_0003);
    rd(A_CTRL, m, n); check("R8 flag cleared by write 1", m, 32'h0000_0002);
    wr(A_CTRL, 32'h0000_0004);
    rd(A_CTRL, m, n); check("R8 enable off, slow on", m, 32'h0000_0004);
    pins[3] = 1'b0; cyc(3); pins[3] = 1'b1; cyc(8);
    check("R7 no irq while port disabled", 32'(irq_main), 32'd0);
  endtask

  task automatic t_narrow();
    logic [31:0] m, n;
    do_reset();
    wr(A_MASK, 32'hFFFF_FFFF);
    wr(A_TLO,  32'hFFFF_FFFF);
    wr(A_THI,  32'hFFFF_FFFF);
    rd(A_MASK, m, n); check("R9 narrow mask upper bits zero", n, 32'h0000_0FFF);
    check("R9 full mask", m, 32'hFFFF_FFFF);
    rd(A_TLO, m, n);  check("R9 narrow type lo", n, 32'h00FF_FFFF);
    rd(A_THI, m, n);  check("R9 narrow type hi", n, 32'h0000_0000);
    wr(A_TLO, 32'd0); wr(A_THI, 32'd0);
    pins = '1; cyc(4);
    rd(A_PEND, m, n); check("R9 narrow pending width", n, 32'h0000_0FFF);
  endtask

  task automatic t_slow_read();
    logic [31:0] m, n;
    do_reset();
    wr(A_CTRL, 32'h0000_0006);
    wr(A_TLO, 32'd2 << 8);
    pins[4] = 1'b1;
    cyc(SDIV + 4);
    rd(A_PEND, m, n); check("R10 slow sample still latches edge", m, 32'h0000_0010);
    wr(A_MASK, 32'h0000_00AA);
    rd(A_MASK, m, n);
    wr(A_MASK, 32'h0000_0055);
    cyc(2);
    check("R11 rdata held without read", rd_main, 32'h0000_00AA);
    rd(A_MASK, m, n); check("R11 rdata after read strobe", m, 32'h0000_0055);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_type_pack();
    t_edges();
    t_level();
    t_clear_collide();
    t_mask_ctrl();
    t_narrow();
    t_slow_read();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule